// File: doc/BRIEF.md
# Exception Level Control Register

This block keeps the exception-level status bit of a small five-stage RISC core, together with the saved return address and the cause code of the most recent exception. Every cycle it looks at three possible exception sources: an interrupt, a fault raised by the pipeline (with its faulting PC, cause code and a flag marking a translation refill miss), and a system-call instruction. It also looks at an exception-return request. From these it produces a fetch redirect in the same cycle, and it updates its stored state on the next clock edge.

An interrupt takes the place of the instruction in flight, and a system call moves the core into the handler. In both cases the saved PC is the current PC. A fault saves the PC that the pipeline reports. An exception-return clears the level bit and sends fetch back to the saved PC. The redirect is always taken from the saved PC as it stood before the cycle.

The key rule covers the collision case. An exception-return can be decoded in the same cycle that a prefetch beyond it faults, for example when the next page has no translation. When that happens, the exception wins. The level bit stays set and fetch goes to the handler vector, not to the return address.

Top module: `exc_level_ctrl`

## Requirements
- R1: After reset the level bit reads 1, the saved PC reads 0, the cause reads 0, and with no request pending the redirect valid output is 0.
- R2: Any taken exception (interrupt, fault or system call) makes the level bit read 1 after the next rising clock edge.
- R3: An exception-return with no exception in the same cycle drives redirect valid high in that cycle, with a target equal to the saved PC held before the cycle. The level bit reads 0 after the next edge.
- R4: When an exception and an exception-return arrive in the same cycle, the redirect target is the handler vector selected by R8, and the level bit reads 1 after the next edge.
- R5: A fault that wins arbitration stores its faulting PC and its 5-bit cause code, which are visible after the next edge.
- R6: An interrupt has the highest priority among the sources. It stores the current PC and cause code 0.
- R7: A system call has the lowest priority among the sources. It stores the current PC and cause code 8. A fault in the same cycle takes precedence over it.
- R8: The redirect target of an exception is 0x80000000 when the winning source is a fault flagged as a refill miss and the level bit currently reads 0. In every other case the target is 0x80000180.
- R9: An exception-return without an exception changes neither the saved PC nor the cause.
- R10: In a cycle with no request, redirect valid is 0, and the level bit, saved PC and cause all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | PC of the instruction in flight |
| irq_req | input | 1 | Interrupt replaces the instruction in flight |
| flt_req | input | 1 | Pipeline fault request |
| flt_pc | input | 32 | PC of the faulting instruction |
| flt_code | input | 5 | Cause code of the fault |
| flt_refill | input | 1 | Fault is a translation refill miss |
| sys_req | input | 1 | System-call instruction |
| eret_req | input | 1 | Exception-return instruction |
| exl | output | 1 | Exception-level bit |
| epc | output | 32 | Saved exception PC |
| cause | output | 5 | Latched cause code |
| redir_valid | output | 1 | Fetch redirect this cycle |
| redir_pc | output | 32 | Redirect target |

## Verification
The hardest situation to reach is the collision of an exception-return with a refill-miss fault while the level bit is clear. Both the refill vector and the level-bit priority are in play only in that corner. To get there, the bench first issues a lone exception-return to clear the bit, then raises the return and a flagged fault together in the next cycle. It then repeats the collision with the bit already set, to show the general vector. A long random phase then biases requests so that returns and faults overlap often, and a behavioural model checks every cycle.

// File: rtl/exl_pkg.sv
package exl_pkg;

  localparam int unsigned PC_W   = 32;
  localparam int unsigned CODE_W = 5;

  // number of exception sources, index order is the priority order
  localparam int unsigned N_SRC       = 3;
  localparam int unsigned SRC_INTR    = 0;
  localparam int unsigned SRC_FAULT   = 1;
  localparam int unsigned SRC_SYSCALL = 2;

  localparam logic [PC_W-1:0]   VEC_GENERAL  = 32'h8000_0180;
  localparam logic [PC_W-1:0]   VEC_REFILL   = 32'h8000_0000;
  localparam logic [CODE_W-1:0] CODE_INTR    = 5'd0;
  localparam logic [CODE_W-1:0] CODE_SYSCALL = 5'd8;

  // handler entry point: the refill entry applies only outside the handler
  function automatic logic [PC_W-1:0] pick_vector(input logic refill_miss,
                                                  input logic level);
    if (refill_miss && !level) return VEC_REFILL;
    return VEC_GENERAL;
  endfunction

  // lowest set index of a request vector, plus a found flag
  function automatic logic [N_SRC:0] first_set(input logic [N_SRC-1:0] req);
    logic [N_SRC:0] res;
    res = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        res = '0;
        res[i] = 1'b1;
        res[N_SRC] = 1'b1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/exc_src_arb.sv
module exc_src_arb
  import exl_pkg::*;
#(
  parameter int unsigned NS  = N_SRC,
  parameter int unsigned PW  = PC_W,
  parameter int unsigned CW  = CODE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NS-1:0]         src_req,
  input  logic [NS-1:0][PW-1:0] src_pc,
  input  logic [NS-1:0][CW-1:0] src_code,
  input  logic [NS-1:0]         src_refill,
  output logic                  take,
  output logic [NS-1:0]         grant,
  output logic [PW-1:0]         win_pc,
  output logic [CW-1:0]         win_code,
  output logic                  win_refill
);

  logic [NS-1:0] grant_c;

  // lowest index wins
  always_comb begin
    grant_c = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (src_req[i]) begin
        grant_c = '0;
        grant_c[i] = 1'b1;
      end
    end
  end

  assign grant = grant_c;
  assign take  = |src_req;

  // one-hot mux of the winning payload
  always_comb begin
    win_pc     = '0;
    win_code   = '0;
    win_refill = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (grant_c[i]) begin
        win_pc     = win_pc | src_pc[i];
        win_code   = win_code | src_code[i];
        win_refill = win_refill | src_refill[i];
      end
    end
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant != '0) == take)); // R6
  AST_TOP_SOURCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    src_req[0] |-> grant[0]); // R6
  AST_LAST_SOURCE_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req[NS-1] && (src_req[NS-2:0] != '0)) |-> !grant[NS-1]); // R7

endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exl_pkg::*;
#(
  parameter int unsigned PW = PC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          win_refill,
  input  logic          eret,
  input  logic          level,
  input  logic [PW-1:0] saved_pc,
  output logic          redir_valid,
  output logic [PW-1:0] redir_pc,
  output logic          ev_collide,
  output logic          ev_return
);

  logic [PW-1:0] vec_pc;

  assign vec_pc      = pick_vector(win_refill, level);
  assign ev_collide  = take && eret;
  assign ev_return   = eret && !take;
  assign redir_valid = take || eret;
  // the exception outranks the return
  assign redir_pc    = take ? vec_pc : saved_pc;

  AST_COLLIDE_TO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_collide |-> (redir_valid &&
                    (redir_pc == VEC_GENERAL || redir_pc == VEC_REFILL))); // R4
  AST_RETURN_TO_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_return |-> (redir_valid && redir_pc == saved_pc)); // R3
  AST_REFILL_ONLY_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_pc == VEC_REFILL && take) |-> !level); // R8

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exl_pkg::*;
#(
  parameter int unsigned PW = PC_W,
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          eret,
  input  logic [PW-1:0] win_pc,
  input  logic [CW-1:0] win_code,
  output logic          level,
  output logic [PW-1:0] saved_pc,
  output logic [CW-1:0] saved_code
);

  logic          level_q;
  logic [PW-1:0] pc_q;
  logic [CW-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      pc_q    <= '0;
      code_q  <= '0;
    end else if (take) begin
      level_q <= 1'b1;
      pc_q    <= win_pc;
      code_q  <= win_code;
    end else if (eret) begin
      level_q <= 1'b0;
    end
  end

  assign level      = level_q;
  assign saved_pc   = pc_q;
  assign saved_code = code_q;

  AST_TAKE_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> level); // R2
  AST_RETURN_CLEARS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !take) |=> !level); // R3
  AST_COLLIDE_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && take) |=> level); // R4
  AST_RETURN_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !take) |=> ($stable(saved_pc) && $stable(saved_code))); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!eret && !take) |=> ($stable(level) && $stable(saved_pc) &&
                          $stable(saved_code))); // R10

endmodule

// File: rtl/exc_level_ctrl.sv
module exc_level_ctrl
  import exl_pkg::*;
#(
  parameter int unsigned PW = PC_W,
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cur_pc,
  input  logic          irq_req,
  input  logic          flt_req,
  input  logic [PW-1:0] flt_pc,
  input  logic [CW-1:0] flt_code,
  input  logic          flt_refill,
  input  logic          sys_req,
  input  logic          eret_req,
  output logic          exl,
  output logic [PW-1:0] epc,
  output logic [CW-1:0] cause,
  output logic          redir_valid,
  output logic [PW-1:0] redir_pc
);

  localparam int unsigned NS = N_SRC;

  logic [NS-1:0]         src_req;
  logic [NS-1:0][PW-1:0] src_pc;
  logic [NS-1:0][CW-1:0] src_code;
  logic [NS-1:0]         src_refill;

  // named internal events for the checks
  logic          ev_take;
  logic [NS-1:0] ev_grant;
  logic          ev_collide;
  logic          ev_return;
  logic [PW-1:0] win_pc;
  logic [CW-1:0] win_code;
  logic          win_refill;
  logic          level;
  logic [PW-1:0] saved_pc;
  logic [CW-1:0] saved_code;

  assign src_req[SRC_INTR]       = irq_req;
  assign src_pc[SRC_INTR]        = cur_pc;
  assign src_code[SRC_INTR]      = CW'(CODE_INTR);
  assign src_refill[SRC_INTR]    = 1'b0;

  assign src_req[SRC_FAULT]      = flt_req;
  assign src_pc[SRC_FAULT]       = flt_pc;
  assign src_code[SRC_FAULT]     = flt_code;
  assign src_refill[SRC_FAULT]   = flt_refill;

  assign src_req[SRC_SYSCALL]    = sys_req;
  assign src_pc[SRC_SYSCALL]     = cur_pc;
  assign src_code[SRC_SYSCALL]   = CW'(CODE_SYSCALL);
  assign src_refill[SRC_SYSCALL] = 1'b0;

  exc_src_arb #(.NS(NS), .PW(PW), .CW(CW)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req    (src_req),
    .src_pc     (src_pc),
    .src_code   (src_code),
    .src_refill (src_refill),
    .take       (ev_take),
    .grant      (ev_grant),
    .win_pc     (win_pc),
    .win_code   (win_code),
    .win_refill (win_refill)
  );

  exc_redirect #(.PW(PW)) u_redir (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (ev_take),
    .win_refill  (win_refill),
    .eret        (eret_req),
    .level       (level),
    .saved_pc    (saved_pc),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .ev_collide  (ev_collide),
    .ev_return   (ev_return)
  );

  exc_state_regs #(.PW(PW), .CW(CW)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (ev_take),
    .eret       (eret_req),
    .win_pc     (win_pc),
    .win_code   (win_code),
    .level      (level),
    .saved_pc   (saved_pc),
    .saved_code (saved_code)
  );

  assign exl   = level;
  assign epc   = saved_pc;
  assign cause = saved_code;

  AST_INTR_STORES_CUR_PC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> (epc == $past(cur_pc) && cause == CW'(CODE_INTR))); // R6
  AST_FAULT_STORES_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_req && !irq_req) |=> (epc == $past(flt_pc) && cause == $past(flt_code))); // R5
  AST_SYSCALL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_req && !irq_req && !flt_req) |=> (cause == CW'(CODE_SYSCALL))); // R7
  AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !flt_req && !sys_req && !eret_req) |-> !redir_valid); // R10
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_collide && ev_return) && (ev_grant != '0 || !ev_take)); // R4

endmodule

// File: tb/test_exc_level_ctrl.sv
module test_exc_level_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cur_pc;
  logic        irq_req, flt_req, flt_refill, sys_req, eret_req;
  logic [31:0] flt_pc;
  logic [4:0]  flt_code;
  logic        exl, redir_valid;
  logic [31:0] epc, redir_pc;
  logic [4:0]  cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit          m_exl;
  logic [31:0] m_epc;
  logic [4:0]  m_cause;

  always #4 clk = ~clk; // 125 MHz

  exc_level_ctrl i_exc_level_ctrl (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .irq_req(irq_req),
    .flt_req(flt_req), .flt_pc(flt_pc), .flt_code(flt_code),
    .flt_refill(flt_refill), .sys_req(sys_req), .eret_req(eret_req),
    .exl(exl), .epc(epc), .cause(cause), .redir_valid(redir_valid),
    .redir_pc(redir_pc)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input bit irq, input bit flt, input bit sys,
                       input bit er, input bit refill,
                       input logic [31:0] cpc, input logic [31:0] fpc,
                       input logic [4:0] code);
    irq_req = irq; flt_req = flt; sys_req = sys; eret_req = er;
    flt_refill = refill; cur_pc = cpc; flt_pc = fpc; flt_code = code;
  endtask

  // one cycle: inputs already set after a falling edge
  task automatic step(input string tag);
    bit          take;
    logic [31:0] s_pc, exp_tgt;
    logic [4:0]  s_code;
    bit          refill_win;
    take = irq_req || flt_req || sys_req;
    refill_win = 0;
    if (irq_req) begin s_pc = cur_pc; s_code = 5'd0; end
    else if (flt_req) begin s_pc = flt_pc; s_code = flt_code; refill_win = flt_refill; end
    else begin s_pc = cur_pc; s_code = 5'd8; end
    if (take) exp_tgt = (refill_win && !m_exl) ? 32'h8000_0000 : 32'h8000_0180;
    else exp_tgt = m_epc;
    #1;
    chk(tag, "redir_valid", {31'd0, redir_valid}, {31'd0, take || eret_req});
    if (take || eret_req) chk(tag, "redir_pc", redir_pc, exp_tgt);
    @(posedge clk);
    if (take) begin m_exl = 1; m_epc = s_pc; m_cause = s_code; end
    else if (eret_req) m_exl = 0;
    @(negedge clk);
    chk(tag, "exl", {31'd0, exl}, {31'd0, m_exl});
    chk(tag, "epc", epc, m_epc);
    chk(tag, "cause", {27'd0, cause}, {27'd0, m_cause});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    drive(0, 0, 0, 0, 0, 32'h0, 32'h0, 5'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_exl = 1; m_epc = '0; m_cause = '0;
    #1;
    // R1 reset state
    chk("R1", "exl", {31'd0, exl}, 32'd1);
    chk("R1", "epc", epc, 32'd0);
    chk("R1", "cause", {27'd0, cause}, 32'd0);
    chk("R1", "redir_valid", {31'd0, redir_valid}, 32'd0);
    @(negedge clk);

    // R3 lone return clears the bit, redirects to saved PC 0
    drive(0, 0, 0, 1, 0, 32'h100, 32'h0, 5'd0); step("R3");
    // R8 R5 refill fault outside the handler
    drive(0, 1, 0, 0, 1, 32'h200, 32'h0000_0ffc, 5'd2); step("R8");
    // R9 return does not touch epc/cause
    drive(0, 0, 0, 1, 0, 32'h300, 32'h0, 5'd0); step("R9");
    // R4 collision with bit clear and refill flag: refill vector, bit stays set
    drive(0, 1, 0, 1, 1, 32'h0000_0ffc, 32'h0000_1000, 5'd2); step("R4");
    // R4 collision with bit set: general vector
    drive(0, 1, 0, 1, 1, 32'h0000_0ffc, 32'h0000_2000, 5'd3); step("R4");
    // R2 R6 interrupt over fault and syscall
    drive(0, 0, 0, 1, 0, 32'h0, 32'h0, 5'd0); step("R3");
    drive(1, 1, 1, 0, 0, 32'h0000_4440, 32'h0000_5550, 5'd7); step("R6");
    // R7 fault beats syscall, then syscall alone
    drive(0, 1, 1, 0, 0, 32'h0000_6660, 32'h0000_7770, 5'd12); step("R7");
    drive(0, 0, 1, 0, 0, 32'h0000_8880, 32'h0, 5'd0); step("R7");
    // R2 exception while bit clear sets it
    drive(0, 0, 0, 1, 0, 32'h0, 32'h0, 5'd0); step("R3");
    drive(0, 0, 1, 0, 0, 32'h0000_9990, 32'h0, 5'd0); step("R2");
    // R10 idle
    drive(0, 0, 0, 0, 1, 32'hdead_0000, 32'hbeef_0000, 5'd31); step("R10");
    step("R10");

    // random phase, overlaps of return and fault made frequent
    for (int n = 0; n < 3000; n++) begin
      bit irq, flt, sys, er;
      string tag;
      irq = ($urandom_range(0, 9) == 0);
      flt = ($urandom_range(0, 2) == 0);
      sys = ($urandom_range(0, 7) == 0);
      er  = ($urandom_range(0, 1) == 0);
      drive(irq, flt, sys, er, 1'($urandom_range(0, 1)), $urandom, $urandom,
            5'($urandom_range(0, 31)));
      if ((irq || flt || sys) && er) tag = "R4";
      else if (irq) tag = "R6";
      else if (flt) tag = "R5";
      else if (sys) tag = "R7";
      else if (er) tag = "R3";
      else tag = "R10";
      step(tag);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule